// File: doc/BRIEF.md
# Access Hook Invocation Controller

This controller sits beside the memory stage of a pipeline and decides, for each load or store reaching that stage, whether a software hook must run before the access. It combines the prediction made at fetch time (carried down the pipeline with the instruction) with the trigger result resolved in the memory stage. When the trigger fires, the access is cancelled in the same cycle. The access address and the instruction PC are latched into two capture registers. In the following cycle fetch is redirected to a fixed hook entry address. When the hook returns to the captured PC, the original access runs again.

A trigger that fetch did not predict also raises a full pipeline flush, because the younger instructions came down the wrong path. A predicted trigger only redirects. Each resolved outcome is reported to the predictor through a two-bit update code with the instruction PC. A prediction that turns out wrong produces only a removal request. Triggering is armed by a segment-start opcode and disarmed by a segment-end opcode. An instruction already killed by an older flush is ignored.

Top module: `hook_ctrl`

## Requirements
- R1: When a trigger fires (mem_valid_i high, mem_squash_i low, hooks armed, mem_trig_i high), the address capture register takes mem_addr_i on that clock edge; rd_data_o shows it when rd_sel_i is 0.
- R2: On the same edge the PC capture register takes mem_pc_i; rd_data_o shows it when rd_sel_i is 1.
- R3: cancel_o is high combinationally in the trigger cycle. In the next cycle redirect_o is high for one cycle, and redirect_pc_o always equals the HOOK_BASE parameter.
- R4: An unpredicted trigger (mem_pred_i low) sets flush_o together with redirect_o, and upd_op_o = 2 (learn) with upd_pc_o = the instruction PC, one cycle after the trigger.
- R5: A predicted trigger (mem_pred_i high) sets redirect_o with flush_o low, and upd_op_o = 1 (mark invoked), one cycle after the trigger.
- R6: A valid, unsquashed access with mem_pred_i high and no trigger gives upd_op_o = 3 (remove) with upd_pc_o = its PC one cycle later. It gives no cancel, redirect or flush.
- R7: A pulse on seg_start_i arms triggering from the next cycle, and seg_end_i disarms it from the next cycle; if both are pulsed together, end wins. While disarmed, mem_trig_i has no effect.
- R8: The capture registers keep their values in every cycle without a trigger (both reset to 0).
- R9: An access with mem_squash_i high produces no cancel, redirect, flush, capture or update (upd_op_o = 0).
- R10: Triggers in back-to-back cycles each produce their own redirect pulse and capture, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| seg_start_i | input | 1 | Segment-start opcode retired: arm triggering |
| seg_end_i | input | 1 | Segment-end opcode retired: disarm triggering |
| mem_valid_i | input | 1 | A load or store is in the memory stage |
| mem_squash_i | input | 1 | That instruction is killed by an older flush |
| mem_trig_i | input | 1 | Trigger condition from the page/stripe filter |
| mem_pred_i | input | 1 | Fetch-time prediction carried with the instruction |
| mem_addr_i | input | XLEN | Data address of the access |
| mem_pc_i | input | XLEN | PC of the access instruction |
| rd_sel_i | input | 1 | Capture register select: 0 address, 1 PC |
| cancel_o | output | 1 | Abort the access in the memory stage |
| redirect_o | output | 1 | One-cycle fetch redirect pulse |
| redirect_pc_o | output | XLEN | Hook entry address |
| flush_o | output | 1 | Full pipeline flush (unpredicted trigger) |
| upd_op_o | output | 2 | Predictor update: 0 none, 1 mark, 2 learn, 3 remove |
| upd_pc_o | output | XLEN | PC for the predictor update |
| rd_data_o | output | XLEN | Selected capture register value |

## Verification
The cases that can land in the same cycle are a segment boundary and a trigger. Arming or disarming can coincide with an access that would trigger. A start and an end can also coincide. The bench provokes both by pulsing the opcodes in the same step as a triggering access. It judges them against a model in which the arm state seen by that access is the one from the previous cycle, and in which end wins over start. A second overlap is a capture update together with a capture read. Every step drives rd_sel_i, and the scoreboard compares rd_data_o with the value the model holds after that cycle's capture.

// File: rtl/hook_pkg.sv
package hook_pkg;
  typedef enum logic [1:0] {
    UPD_NONE  = 2'd0,
    UPD_MARK  = 2'd1,
    UPD_LEARN = 2'd2,
    UPD_DROP  = 2'd3
  } upd_op_e;
endpackage

// File: rtl/hook_gate.sv
module hook_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic end_i,
  output logic armed_o
);
  logic armed_q, armed_d;

  always_comb begin
    armed_d = armed_q;
    if (end_i)        armed_d = 1'b0;
    else if (start_i) armed_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= armed_d;
  end

  assign armed_o = armed_q;
endmodule

// File: rtl/hook_resolve.sv
module hook_resolve
  import hook_pkg::*;
(
  input  logic    valid_i,
  input  logic    squash_i,
  input  logic    armed_i,
  input  logic    trig_i,
  input  logic    pred_i,
  output logic    fire_o,
  output logic    flush_o,
  output upd_op_e op_o
);
  logic live;

  always_comb begin
    live    = valid_i && !squash_i;
    fire_o  = live && armed_i && trig_i;
    flush_o = fire_o && !pred_i;
    op_o    = UPD_NONE;
    if (fire_o)              op_o = pred_i ? UPD_MARK : UPD_LEARN;
    else if (live && pred_i) op_o = UPD_DROP;
  end
endmodule

// File: rtl/hook_capture.sv
module hook_capture #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_i,
  input  logic [XLEN-1:0] addr_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic            sel_i,
  output logic [XLEN-1:0] cap_addr_o,
  output logic [XLEN-1:0] cap_pc_o,
  output logic [XLEN-1:0] rd_data_o
);
  localparam int NCAP = 2;

  logic [XLEN-1:0] src [NCAP];
  logic [XLEN-1:0] cap_q [NCAP];

  assign src[0] = addr_i;
  assign src[1] = pc_i;

  for (genvar g = 0; g < NCAP; g++) begin : g_cap
    logic [XLEN-1:0] cap_d;
    always_comb cap_d = load_i ? src[g] : cap_q[g];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cap_q[g] <= '0;
      else        cap_q[g] <= cap_d;
    end
  end

  assign cap_addr_o = cap_q[0];
  assign cap_pc_o   = cap_q[1];
  assign rd_data_o  = sel_i ? cap_q[1] : cap_q[0];
endmodule

// File: rtl/hook_ctrl.sv
module hook_ctrl
  import hook_pkg::*;
#(
  parameter int              XLEN      = 32,
  parameter logic [XLEN-1:0] HOOK_BASE = 32'h0000_4000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            seg_start_i,
  input  logic            seg_end_i,
  input  logic            mem_valid_i,
  input  logic            mem_squash_i,
  input  logic            mem_trig_i,
  input  logic            mem_pred_i,
  input  logic [XLEN-1:0] mem_addr_i,
  input  logic [XLEN-1:0] mem_pc_i,
  input  logic            rd_sel_i,
  output logic            cancel_o,
  output logic            redirect_o,
  output logic [XLEN-1:0] redirect_pc_o,
  output logic            flush_o,
  output logic [1:0]      upd_op_o,
  output logic [XLEN-1:0] upd_pc_o,
  output logic [XLEN-1:0] rd_data_o
);
  localparam int SYNC_N = 2;

  // reset: asserted asynchronously, released on a clock edge
  logic [SYNC_N-1:0] rsync_q;
  logic              rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[SYNC_N-2:0], 1'b1};
  end
  assign rst_int_n = rsync_q[SYNC_N-1];

  logic    armed, fire, need_flush;
  upd_op_e op;
  logic [XLEN-1:0] cap_addr_w, cap_pc_w;

  hook_gate u_gate (
    .clk(clk), .rst_n(rst_int_n),
    .start_i(seg_start_i), .end_i(seg_end_i), .armed_o(armed)
  );

  hook_resolve u_res (
    .valid_i(mem_valid_i), .squash_i(mem_squash_i), .armed_i(armed),
    .trig_i(mem_trig_i), .pred_i(mem_pred_i),
    .fire_o(fire), .flush_o(need_flush), .op_o(op)
  );

  hook_capture #(.XLEN(XLEN)) u_cap (
    .clk(clk), .rst_n(rst_int_n), .load_i(fire),
    .addr_i(mem_addr_i), .pc_i(mem_pc_i), .sel_i(rd_sel_i),
    .cap_addr_o(cap_addr_w), .cap_pc_o(cap_pc_w), .rd_data_o(rd_data_o)
  );

  // registered steering outputs
  logic            redir_q, redir_d, flush_q, flush_d;
  upd_op_e         op_q, op_d;
  logic [XLEN-1:0] upc_q, upc_d;
  logic            upc_en;

  always_comb begin
    redir_d = fire;
    flush_d = need_flush;
    op_d    = op;
    upc_en  = (op != UPD_NONE);
    upc_d   = upc_en ? mem_pc_i : upc_q;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      redir_q <= 1'b0;
      flush_q <= 1'b0;
      op_q    <= UPD_NONE;
      upc_q   <= '0;
    end else begin
      redir_q <= redir_d;
      flush_q <= flush_d;
      op_q    <= op_d;
      upc_q   <= upc_d;
    end
  end

  assign cancel_o      = fire;
  assign redirect_o    = redir_q;
  assign redirect_pc_o = HOOK_BASE;
  assign flush_o       = flush_q;
  assign upd_op_o      = op_q;
  assign upd_pc_o      = upc_q;
endmodule

// File: rtl/hook_ctrl_chk.sv
module hook_ctrl_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            mem_valid_i,
  input logic            mem_squash_i,
  input logic [XLEN-1:0] mem_addr_i,
  input logic [XLEN-1:0] mem_pc_i,
  input logic            cancel_o,
  input logic            redirect_o,
  input logic            flush_o,
  input logic [1:0]      upd_op_o,
  input logic [XLEN-1:0] cap_addr,
  input logic [XLEN-1:0] cap_pc
);
  AST_CANCEL_THEN_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    cancel_o |=> redirect_o); // R3
  AST_ADDR_CAPTURED: assert property (@(posedge clk) disable iff (!rst_n)
    cancel_o |=> (cap_addr == $past(mem_addr_i))); // R1
  AST_PC_CAPTURED: assert property (@(posedge clk) disable iff (!rst_n)
    cancel_o |=> (cap_pc == $past(mem_pc_i))); // R2
  AST_FLUSH_NEEDS_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    flush_o |-> (redirect_o && upd_op_o == 2'd2)); // R4
  AST_MARK_NO_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_op_o == 2'd1) |-> (redirect_o && !flush_o)); // R5
  AST_DROP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_op_o == 2'd3) |-> (!redirect_o && !flush_o)); // R6
  AST_CAPTURE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cancel_o |=> ($stable(cap_addr) && $stable(cap_pc))); // R8
  AST_SQUASH_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid_i && mem_squash_i) |-> !cancel_o); // R9
  AST_SQUASH_NO_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid_i && mem_squash_i) |=> (upd_op_o == 2'd0 && !redirect_o)); // R9
endmodule

bind hook_ctrl hook_ctrl_chk #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .mem_valid_i(mem_valid_i), .mem_squash_i(mem_squash_i),
  .mem_addr_i(mem_addr_i), .mem_pc_i(mem_pc_i),
  .cancel_o(cancel_o), .redirect_o(redirect_o), .flush_o(flush_o),
  .upd_op_o(upd_op_o), .cap_addr(cap_addr_w), .cap_pc(cap_pc_w)
);

// File: tb/tb_hook_ctrl.sv
module tb_hook_ctrl;
  localparam int XLEN = 32;
  localparam logic [XLEN-1:0] BASE = 32'h0000_4000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  logic seg_start, seg_end, valid, squash, trig, pred, sel;
  logic [XLEN-1:0] addr, pc;
  logic cancel, redirect, flush;
  logic [XLEN-1:0] redirect_pc, upd_pc, rd_data;
  logic [1:0] upd_op;

  hook_ctrl #(.XLEN(XLEN), .HOOK_BASE(BASE)) dut (
    .clk(clk), .rst_n(rst_n), .seg_start_i(seg_start), .seg_end_i(seg_end),
    .mem_valid_i(valid), .mem_squash_i(squash), .mem_trig_i(trig),
    .mem_pred_i(pred), .mem_addr_i(addr), .mem_pc_i(pc), .rd_sel_i(sel),
    .cancel_o(cancel), .redirect_o(redirect), .redirect_pc_o(redirect_pc),
    .flush_o(flush), .upd_op_o(upd_op), .upd_pc_o(upd_pc), .rd_data_o(rd_data)
  );

  typedef struct {
    logic            redir;
    logic            fl;
    logic [1:0]      op;
    logic [XLEN-1:0] upc;
    logic [XLEN-1:0] rd;
    string           tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference state
  logic            m_en = 1'b0;
  logic [XLEN-1:0] m_ca = '0;
  logic [XLEN-1:0] m_cp = '0;

  task automatic step(input logic v, input logic sq, input logic t, input logic p,
                      input logic [XLEN-1:0] a, input logic [XLEN-1:0] c,
                      input logic st, input logic en_end, input logic s, input string tag);
    exp_t e;
    logic fire, live;
    @(negedge clk);
    valid = v; squash = sq; trig = t; pred = p; addr = a; pc = c;
    seg_start = st; seg_end = en_end; sel = s;
    live = v && !sq;
    fire = live && m_en && t;
    e.redir = fire;
    e.fl    = fire && !p;
    e.op    = fire ? (p ? 2'd1 : 2'd2) : ((live && p) ? 2'd3 : 2'd0);
    e.upc   = c;
    if (fire) begin m_ca = a; m_cp = c; end
    e.rd    = s ? m_cp : m_ca;
    e.tag   = tag;
    if (en_end) m_en = 1'b0;
    else if (st) m_en = 1'b1;
    q.push_back(e);
    #1;
    checks++;
    if (cancel !== fire) begin
      fails++;
      $display("FAIL %s cancel: actual %0b expected %0b", tag, cancel, fire);
    end
  endtask

  // monitor: compares registered results one clock after each step
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        bit bad;
        e = q.pop_front();
        checks++;
        bad = (redirect !== e.redir) || (flush !== e.fl) || (upd_op !== e.op) ||
              (rd_data !== e.rd) || (e.op != 2'd0 && upd_pc !== e.upc) ||
              (redirect_pc !== BASE);
        if (bad) begin
          fails++;
          $display("FAIL %s: actual redir=%0b flush=%0b op=%0d upc=%h rd=%h base=%h expected redir=%0b flush=%0b op=%0d upc=%h rd=%h base=%h",
                   e.tag, redirect, flush, upd_op, upd_pc, rd_data, redirect_pc,
                   e.redir, e.fl, e.op, e.upc, e.rd, BASE);
        end
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    valid = 0; squash = 0; trig = 0; pred = 0; addr = '0; pc = '0;
    seg_start = 0; seg_end = 0; sel = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (redirect !== 0 || flush !== 0 || upd_op !== 0 || rd_data !== 0 || cancel !== 0) begin
      fails++;
      $display("FAIL R8 reset: actual redir=%0b flush=%0b op=%0d rd=%h expected all zero",
               redirect, flush, upd_op, rd_data);
    end

    step(1,0,1,0,32'hA000_0010,32'h0000_1000,0,0,0,"R7 disarmed trigger ignored");
    step(0,0,0,0,'0,'0,1,0,0,"R7 arm");
    step(1,0,1,0,32'hA000_0040,32'h0000_1004,0,0,0,"R4 R1 unpredicted trigger");
    step(0,0,0,0,'0,'0,0,0,1,"R2 pc readback");
    step(1,0,1,1,32'hA000_0080,32'h0000_1008,0,0,1,"R5 predicted trigger");
    step(1,0,0,1,32'hB000_0000,32'h0000_100C,0,0,0,"R6 predicted no trigger");
    step(1,0,0,0,32'hB000_0004,32'h0000_1010,0,0,1,"R8 plain access holds capture");
    step(1,1,1,0,32'hC000_0000,32'h0000_1014,0,0,0,"R9 squashed trigger");
    step(1,1,0,1,32'hC000_0004,32'h0000_1018,0,0,1,"R9 squashed predicted");
    step(1,0,1,0,32'hD000_0000,32'h0000_2000,0,0,0,"R10 first of pair");
    step(1,0,1,1,32'hD000_0100,32'h0000_2004,0,0,1,"R10 second of pair");
    step(0,0,0,0,'0,'0,0,0,0,"R10 after pair addr");
    step(1,0,1,0,32'hE000_0000,32'h0000_3000,1,1,0,"R7 start+end with trigger");
    step(1,0,1,0,32'hE000_0040,32'h0000_3004,0,0,0,"R7 end wins");
    step(0,0,0,0,'0,'0,1,0,0,"R7 rearm");
    step(1,0,1,0,32'hE000_0080,32'h0000_3008,0,1,0,"R7 trigger on end cycle");
    step(1,0,1,1,32'hE000_00C0,32'h0000_300C,0,0,1,"R7 disarmed after end");
    step(0,0,0,0,'0,'0,1,0,0,"R3 rearm");

    lfsr = 16'hACE1;
    for (int i = 0; i < 60; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0], lfsr[1] & lfsr[2], lfsr[3] | lfsr[4], lfsr[5],
           {lfsr, lfsr ^ 16'h5A5A}, {16'h0000, lfsr ^ 16'h1234},
           lfsr[6] & lfsr[7], lfsr[8] & lfsr[9] & lfsr[10], lfsr[11],
           "R1 R2 R3 R4 R5 R6 random mix");
    end
    step(0,0,0,0,'0,'0,0,0,0,"drain");
    step(0,0,0,0,'0,'0,0,0,1,"drain");
    @(posedge clk); #2;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule